// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps a small group of cores coherent. Each core has a private direct-mapped cache of 64-byte lines, eight 64-bit words each. Every line is tracked in one of four states: Invalid, Shared, Exclusive or Modified. A core issues one word read or word write at a time. Hits that need no ownership change finish locally. All other accesses go onto a single shared snoop bus. A round-robin arbiter grants that bus to one core per cycle.

A bus transaction is a read (RD), a read-for-ownership (RFO) or a writeback (WB). Each transaction completes in the cycle it is granted. Every other cache looks up the line in that cycle and answers with a hit flag and a dirty flag; a dirty holder also drives its line. The answers are OR-combined. A dirty holder supplies the line cache-to-cache, and the memory model behind the bus takes the same data in the same cycle. Otherwise the line comes from memory. Writebacks of evicted Modified lines go to memory. The bus activity is visible on output ports so that the surrounding system can trace it.

Top module: `mesi_snoop_top`

## Requirements
- R1: After reset every line in every cache is Invalid, no core_done is raised and bus_valid is low. Line states are reported as I=0, S=1, E=2, M=3.
- R2: A read that misses issues one RD transaction (bus_op=0). The requester ends in E (2) when bus_shared is low, or in S (1) when any other cache reports a copy. core_rdata returns the current coherent value of the word.
- R3: A write to a line that is Invalid or Shared in the writer issues one RFO transaction (bus_op=1). Every other copy becomes Invalid, and the writer ends in M (3) with the written word merged into the fetched line.
- R4: A write to a line held in E moves it to M with no bus transaction. Every write returns the written word on core_rdata.
- R5: A read hit in M, E or S, and a write hit in M, cause no bus transaction and leave the line state unchanged.
- R6: When another cache reads or takes ownership of a line held in M, bus_dirty is high and the holder's line is the data delivered. Memory stores that line in the same cycle. On a read, holder and requester both end in S.
- R7: When another cache reads a line held in E, the holder moves to S. A holder already in S stays in S.
- R8: A miss whose direct-mapped slot holds a different line in M first issues a WB transaction (bus_op=2) for the old line, then the fill; memory then holds the written-back data. A clean victim is dropped with no WB.
- R9: At no time do two caches hold the same line when either of them holds it in M or E.
- R10: At most one core is granted per cycle, and only a requesting core. Priority starts at the core after the last one granted and wraps around, so every requester is served.
- R11: core_addr is a word address: bits [2:0] select the word in the line, bits [4:3] the cache slot, and the upper bits the tag. An access to any word acts on the state of the whole line, so a read of another word of a filled line hits. Memory word w of line L resets to {16'hC0DE, L, 16'h5A5A, w}, each field 16 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | N_CORES | One-cycle request pulse per core |
| core_we | input | N_CORES | Request is a write |
| core_addr | input | N_CORES*ADDR_W | Word address per core |
| core_wdata | input | N_CORES*64 | Write word per core |
| core_done | output | N_CORES | One-cycle completion pulse |
| core_rdata | output | N_CORES*64 | Read word, or the written word for writes |
| core_state | output | N_CORES*2 | Line state after the access completes |
| bus_valid | output | 1 | A transaction occupies the bus this cycle |
| bus_owner | output | ID_W | Index of the granted core |
| bus_op | output | 2 | RD=0, RFO=1, WB=2 |
| bus_line | output | ADDR_W-3 | Line address of the transaction |
| bus_shared | output | 1 | OR of other caches' hit answers |
| bus_dirty | output | 1 | OR of other caches' dirty answers |

## Verification
A wrong line state shows at the ports within one access of the point where it goes wrong. A stale E or M left behind shows as a missing RD or RFO on the bus, a wrong bus_shared or bus_dirty flag on the next access to that line, or a wrong core_state on completion. Lost dirty data shows as a wrong core_rdata on the next reader, which may be on another core or may read after an eviction has forced the line through memory. Arbitration faults show in the order of bus_owner values when several cores request in the same cycle.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
    localparam int WORD_W     = 64;
    localparam int LINE_WORDS = 8;
    localparam int WSEL_W     = $clog2(LINE_WORDS);
    localparam int LINE_W     = WORD_W * LINE_WORDS;

    typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_e;
    typedef enum logic [1:0] {OP_RD = 2'd0, OP_RFO = 2'd1, OP_WB = 2'd2} bus_op_e;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t get_word(line_t ln, logic [WSEL_W-1:0] w);
        return ln[w*WORD_W +: WORD_W];
    endfunction

    function automatic line_t put_word(line_t ln, logic [WSEL_W-1:0] w, word_t d);
        line_t r;
        r = ln;
        r[w*WORD_W +: WORD_W] = d;
        return r;
    endfunction

    function automatic line_t seed_line(int unsigned la);
        line_t r;
        for (int w = 0; w < LINE_WORDS; w++)
            r[w*WORD_W +: WORD_W] = {16'hC0DE, 16'(la), 16'h5A5A, 16'(w)};
        return r;
    endfunction
endpackage

// File: rtl/mesi_arbiter.sv
module mesi_arbiter #(
    parameter int N    = 3,
    parameter int ID_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    req,
    output logic [N-1:0]    gnt,
    output logic [ID_W-1:0] gid
);
    logic [ID_W-1:0] ptr;
    logic [ID_W-1:0] cand;
    logic            found;

    always_comb begin
        gnt   = '0;
        gid   = '0;
        found = 1'b0;
        cand  = '0;
        for (int k = 0; k < N; k++) begin
            cand = ID_W'((int'(ptr) + k) % N);
            if (!found && req[cand]) begin
                found     = 1'b1;
                gnt[cand] = 1'b1;
                gid       = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr <= '0;
        else if (found) ptr <= (int'(gid) == N - 1) ? '0 : gid + 1'b1;
    end

    assert_one_grant_R10: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
    assert_grant_needs_req_R10: assert property (@(posedge clk) disable iff (rst) (gnt & ~req) == '0);
endmodule

// File: rtl/mesi_memory.sv
module mesi_memory
    import mesi_pkg::*;
#(
    parameter int LA_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_valid,
    input  bus_op_e         bus_op,
    input  logic [LA_W-1:0] bus_line,
    input  line_t           wb_data,
    input  logic            sup_dirty,
    input  line_t           sup_data,
    output line_t           rd_data
);
    localparam int DEPTH = 1 << LA_W;
    line_t mem [DEPTH];

    assign rd_data = mem[bus_line];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= seed_line(i);
        end else if (bus_valid) begin
            if (bus_op == OP_WB) mem[bus_line] <= wb_data;
            else if (sup_dirty)  mem[bus_line] <= sup_data;
        end
    end

    assert_wb_captured_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_op == OP_WB) |=> mem[$past(bus_line)] == $past(wb_data));
endmodule

// File: rtl/mesi_cache.sv
module mesi_cache
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int N_SETS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  word_t                    wdata,
    output logic                     done,
    output word_t                    rdata,
    output line_st_e                 st_out,
    output logic                     bus_req,
    input  logic                     bus_gnt,
    output bus_op_e                  my_op,
    output logic [ADDR_W-WSEL_W-1:0] my_line,
    output line_t                    my_wb,
    input  logic                     bus_valid,
    input  bus_op_e                  bus_op,
    input  logic [ADDR_W-WSEL_W-1:0] bus_line,
    input  line_t                    fill_data,
    input  logic                     fill_shared,
    output logic                     snp_hit,
    output logic                     snp_dirty,
    output logic                     snp_excl,
    output line_t                    snp_data
);
    localparam int LA_W  = ADDR_W - WSEL_W;
    localparam int IDX_W = $clog2(N_SETS);
    localparam int TAG_W = LA_W - IDX_W;

    typedef enum logic [1:0] {C_IDLE, C_LOOK, C_BUS} ctl_e;
    ctl_e cst;

    logic [TAG_W-1:0] tag_arr [N_SETS];
    line_st_e         st_arr  [N_SETS];
    line_t            dat_arr [N_SETS];

    logic              p_we;
    logic [ADDR_W-1:0] p_addr;
    word_t             p_wdata;

    logic [LA_W-1:0]   p_line;
    logic [IDX_W-1:0]  p_idx, s_idx;
    logic [TAG_W-1:0]  p_tag, s_tag;
    logic [WSEL_W-1:0] p_w;
    line_st_e          cur_st, s_st, fill_st;
    logic              tag_eq, hit, owned, vic_dirty, snoop_here;
    line_t             fill_m;

    assign p_line  = p_addr[ADDR_W-1:WSEL_W];
    assign p_w     = p_addr[WSEL_W-1:0];
    assign p_idx   = p_line[IDX_W-1:0];
    assign p_tag   = p_line[LA_W-1:IDX_W];
    assign cur_st  = st_arr[p_idx];
    assign tag_eq  = tag_arr[p_idx] == p_tag;
    assign hit     = tag_eq && cur_st != ST_I;
    assign owned   = hit && (cur_st == ST_E || cur_st == ST_M);
    assign vic_dirty = !tag_eq && cur_st == ST_M;

    assign bus_req = cst == C_BUS;
    assign my_op   = vic_dirty ? OP_WB : (p_we ? OP_RFO : OP_RD);
    assign my_line = vic_dirty ? {tag_arr[p_idx], p_idx} : p_line;
    assign my_wb   = dat_arr[p_idx];

    assign fill_m  = p_we ? put_word(fill_data, p_w, p_wdata) : fill_data;
    assign fill_st = p_we ? ST_M : (fill_shared ? ST_S : ST_E);

    // snoop side: answer for any transaction granted to another core
    assign s_idx     = bus_line[IDX_W-1:0];
    assign s_tag     = bus_line[LA_W-1:IDX_W];
    assign s_st      = st_arr[s_idx];
    assign snp_hit   = bus_valid && !bus_gnt && bus_op != OP_WB &&
                       s_st != ST_I && tag_arr[s_idx] == s_tag;
    assign snp_dirty = snp_hit && s_st == ST_M;
    assign snp_excl  = snp_hit && (s_st == ST_M || s_st == ST_E);
    assign snp_data  = dat_arr[s_idx];
    assign snoop_here = snp_hit && s_idx == p_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            cst     <= C_IDLE;
            done    <= 1'b0;
            rdata   <= '0;
            st_out  <= ST_I;
            p_we    <= 1'b0;
            p_addr  <= '0;
            p_wdata <= '0;
            for (int i = 0; i < N_SETS; i++) begin
                st_arr[i]  <= ST_I;
                tag_arr[i] <= '0;
                dat_arr[i] <= '0;
            end
        end else begin
            done <= 1'b0;
            if (snp_hit) st_arr[s_idx] <= (bus_op == OP_RFO) ? ST_I : ST_S;
            unique case (cst)
                C_IDLE: if (req) begin
                    p_we    <= we;
                    p_addr  <= addr;
                    p_wdata <= wdata;
                    cst     <= C_LOOK;
                end
                C_LOOK: if (!snoop_here) begin
                    if (hit && (!p_we || owned)) begin
                        if (p_we) begin
                            dat_arr[p_idx] <= put_word(dat_arr[p_idx], p_w, p_wdata);
                            st_arr[p_idx]  <= ST_M;
                            rdata          <= p_wdata;
                            st_out         <= ST_M;
                        end else begin
                            rdata  <= get_word(dat_arr[p_idx], p_w);
                            st_out <= cur_st;
                        end
                        done <= 1'b1;
                        cst  <= C_IDLE;
                    end else begin
                        cst <= C_BUS;
                    end
                end
                C_BUS: if (bus_gnt) begin
                    if (my_op == OP_WB) begin
                        st_arr[p_idx] <= ST_I;
                    end else begin
                        dat_arr[p_idx] <= fill_m;
                        tag_arr[p_idx] <= p_tag;
                        st_arr[p_idx]  <= fill_st;
                        st_out         <= fill_st;
                        rdata          <= p_we ? p_wdata : get_word(fill_data, p_w);
                        done           <= 1'b1;
                        cst            <= C_IDLE;
                    end
                end
                default: cst <= C_IDLE;
            endcase
        end
    end

    assert_write_leaves_m_R4: assert property (@(posedge clk) disable iff (rst)
        (done && p_we) |-> st_arr[p_idx] == ST_M);
    assert_rfo_snoop_inval_R3: assert property (@(posedge clk) disable iff (rst)
        (snp_hit && bus_op == OP_RFO) |=> st_arr[$past(s_idx)] == ST_I);
    assert_rd_snoop_shared_R7: assert property (@(posedge clk) disable iff (rst)
        (snp_hit && bus_op == OP_RD) |=> st_arr[$past(s_idx)] == ST_S);
endmodule

// File: rtl/mesi_snoop_top.sv
module mesi_snoop_top
    import mesi_pkg::*;
#(
    parameter int N_CORES = 3,
    parameter int ADDR_W  = 9,
    parameter int N_SETS  = 4,
    parameter int ID_W    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_CORES-1:0]          core_req,
    input  logic [N_CORES-1:0]          core_we,
    input  logic [N_CORES*ADDR_W-1:0]   core_addr,
    input  logic [N_CORES*WORD_W-1:0]   core_wdata,
    output logic [N_CORES-1:0]          core_done,
    output logic [N_CORES*WORD_W-1:0]   core_rdata,
    output logic [N_CORES*2-1:0]        core_state,
    output logic                        bus_valid,
    output logic [ID_W-1:0]             bus_owner,
    output logic [1:0]                  bus_op,
    output logic [ADDR_W-WSEL_W-1:0]    bus_line,
    output logic                        bus_shared,
    output logic                        bus_dirty
);
    localparam int LA_W = ADDR_W - WSEL_W;

    logic [N_CORES-1:0] breq, gnt, hit_vec, dirty_vec, excl_vec;
    logic [ID_W-1:0]    gid;
    bus_op_e            c_op   [N_CORES];
    logic [LA_W-1:0]    c_line [N_CORES];
    line_t              c_wb   [N_CORES];
    line_t              c_sd   [N_CORES];
    line_st_e           c_st   [N_CORES];
    bus_op_e            op_q;
    line_t              sup_data, mem_rd, fill_data;

    mesi_arbiter #(.N(N_CORES), .ID_W(ID_W)) u_arb (
        .clk(clk), .rst(rst), .req(breq), .gnt(gnt), .gid(gid)
    );

    assign bus_valid  = |gnt;
    assign bus_owner  = gid;
    assign op_q       = c_op[gid];
    assign bus_op     = op_q;
    assign bus_line   = c_line[gid];
    assign bus_shared = |hit_vec;
    assign bus_dirty  = |dirty_vec;

    always_comb begin
        sup_data = '0;
        for (int i = 0; i < N_CORES; i++)
            if (dirty_vec[i]) sup_data = sup_data | c_sd[i];
    end

    assign fill_data = bus_dirty ? sup_data : mem_rd;

    mesi_memory #(.LA_W(LA_W)) u_mem (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_op(op_q),
        .bus_line(bus_line), .wb_data(c_wb[gid]), .sup_dirty(bus_dirty),
        .sup_data(sup_data), .rd_data(mem_rd)
    );

    for (genvar i = 0; i < N_CORES; i++) begin : g_core
        mesi_cache #(.ADDR_W(ADDR_W), .N_SETS(N_SETS)) u_cache (
            .clk(clk), .rst(rst),
            .req(core_req[i]), .we(core_we[i]),
            .addr(core_addr[i*ADDR_W +: ADDR_W]),
            .wdata(core_wdata[i*WORD_W +: WORD_W]),
            .done(core_done[i]),
            .rdata(core_rdata[i*WORD_W +: WORD_W]),
            .st_out(c_st[i]),
            .bus_req(breq[i]), .bus_gnt(gnt[i]),
            .my_op(c_op[i]), .my_line(c_line[i]), .my_wb(c_wb[i]),
            .bus_valid(bus_valid), .bus_op(op_q), .bus_line(bus_line),
            .fill_data(fill_data), .fill_shared(bus_shared),
            .snp_hit(hit_vec[i]), .snp_dirty(dirty_vec[i]),
            .snp_excl(excl_vec[i]), .snp_data(c_sd[i])
        );
        assign core_state[2*i +: 2] = c_st[i];
    end

    assert_single_owner_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && excl_vec != '0) |-> $countones(hit_vec) == 1);
    assert_one_dirty_supplier_R6: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> $countones(dirty_vec) <= 1);
endmodule

// File: tb/mesi_snoop_top_tb.sv
module mesi_snoop_top_tb;
    localparam int NC = 3;
    localparam int AW = 9;
    localparam logic [1:0] I = 0, S = 1, E = 2, M = 3;
    localparam logic [1:0] RD = 0, RFO = 1, WB = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NC-1:0]    core_req = '0, core_we = '0, core_done;
    logic [NC*AW-1:0] core_addr = '0;
    logic [NC*64-1:0] core_wdata = '0, core_rdata;
    logic [NC*2-1:0]  core_state;
    logic             bus_valid, bus_shared, bus_dirty;
    logic [1:0]       bus_owner, bus_op;
    logic [5:0]       bus_line;

    always #2.5 clk = ~clk;

    mesi_snoop_top #(.N_CORES(NC), .ADDR_W(AW), .N_SETS(4)) u_dut (
        .clk(clk), .rst(rst), .core_req(core_req), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_done(core_done),
        .core_rdata(core_rdata), .core_state(core_state), .bus_valid(bus_valid),
        .bus_owner(bus_owner), .bus_op(bus_op), .bus_line(bus_line),
        .bus_shared(bus_shared), .bus_dirty(bus_dirty)
    );

    typedef struct { logic [63:0] rd; logic [1:0] st; string rq; } exp_t;
    exp_t        sbq [NC][$];
    logic [11:0] busq [$];
    logic [63:0] gold [int unsigned];
    int total = 0, failed = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [8:0] mk(int tag, int idx, int w);
        return 9'({tag[3:0], idx[1:0], w[2:0]});
    endfunction

    function automatic logic [63:0] gval(logic [8:0] a);
        if (gold.exists(int'(a))) return gold[int'(a)];
        return {16'hC0DE, 16'(a[8:3]), 16'h5A5A, 16'(a[2:0])};
    endfunction

    // driver: post a request and push its expected result
    task automatic post(int c, bit we, logic [8:0] a, logic [63:0] wd, logic [1:0] st, string rq);
        exp_t e;
        e.rd = we ? wd : gval(a);
        e.st = st;
        e.rq = rq;
        if (we) gold[int'(a)] = wd;
        sbq[c].push_back(e);
        core_req[c] = 1'b1;
        core_we[c]  = we;
        core_addr[c*AW +: AW]  = a;
        core_wdata[c*64 +: 64] = wd;
    endtask

    task automatic run();
        @(negedge clk);
        core_req = '0;
        while (sbq[0].size() + sbq[1].size() + sbq[2].size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic one(int c, bit we, logic [8:0] a, logic [63:0] wd, logic [1:0] st, string rq);
        busq.delete();
        post(c, we, a, wd, st, rq);
        run();
    endtask

    task automatic chk_bus(int n, int k, int own, logic [1:0] op, logic [5:0] ln,
                           bit sh, bit dt, string rq);
        logic [11:0] ex;
        ex = {2'(own), op, ln, sh, dt};
        if (k == 0) chk(busq.size() == n, rq, "bus txn count", 64'(busq.size()), 64'(n));
        if (k < busq.size()) chk(busq[k] == ex, rq, "bus txn", 64'(busq[k]), 64'(ex));
        else chk(1'b0, rq, "bus txn missing", 64'(busq.size()), 64'(k + 1));
    endtask

    // monitor: pops the scoreboard on completions, records bus traffic
    always @(negedge clk) begin : mon
        exp_t e;
        if (!rst) begin
            for (int c = 0; c < NC; c++) begin
                if (core_done[c]) begin
                    if (sbq[c].size() == 0) begin
                        chk(1'b0, "R5", "done with nothing pending", 64'(c), 64'hFF);
                    end else begin
                        e = sbq[c].pop_front();
                        chk(core_rdata[c*64 +: 64] == e.rd, e.rq, "rdata", core_rdata[c*64 +: 64], e.rd);
                        chk(core_state[2*c +: 2] == e.st, e.rq, "state", 64'(core_state[2*c +: 2]), 64'(e.st));
                    end
                end
            end
            if (bus_valid) busq.push_back({bus_owner, bus_op, bus_line, bus_shared, bus_dirty});
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired", 64'd20000, 64'd0);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    localparam int TA = 1, TB = 2, TC = 3, TD = 4;
    initial begin
        logic [63:0] x1, x2, x3, x4, x5, x6;
        x1 = 64'h1111_0000_0000_0001; x2 = 64'h2222_0000_0000_0002;
        x3 = 64'h3333_0000_0000_0003; x4 = 64'h4444_0000_0000_0004;
        x5 = 64'h5555_0000_0000_0005; x6 = 64'h6666_0000_0000_0006;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(core_done == '0, "R1", "done after reset", 64'(core_done), 0);
        chk(bus_valid == 1'b0, "R1", "bus idle after reset", 64'(bus_valid), 0);
        chk(core_state == '0, "R1", "state after reset", 64'(core_state), 0);

        // R1/R2 first read of A: RD, no sharers -> E
        one(0, 0, mk(TA,1,0), 0, E, "R2");
        chk_bus(1, 0, 0, RD, {4'(TA), 2'd1}, 0, 0, "R2");
        // R11 other word of same line hits
        one(0, 0, mk(TA,1,5), 0, E, "R11");
        chk(busq.size() == 0, "R11", "no bus on word hit", 64'(busq.size()), 0);
        // R4 silent E->M
        one(0, 1, mk(TA,1,5), x1, M, "R4");
        chk(busq.size() == 0, "R4", "no bus on E write", 64'(busq.size()), 0);
        // R5 hits in M
        one(0, 0, mk(TA,1,5), 0, M, "R5");
        one(0, 1, mk(TA,1,2), x2, M, "R5");
        chk(busq.size() == 0, "R5", "no bus on M hits", 64'(busq.size()), 0);
        // R6 remote read of M line: dirty supply, both S
        one(1, 0, mk(TA,1,5), 0, S, "R6");
        chk_bus(1, 0, 1, RD, {4'(TA), 2'd1}, 1, 1, "R6");
        one(0, 0, mk(TA,1,2), 0, S, "R6");
        chk(busq.size() == 0, "R6", "holder downgraded to S", 64'(busq.size()), 0);
        // R8 clean victim dropped; R2 shared fill; R7 E holder -> S
        one(0, 0, mk(TB,1,0), 0, E, "R8");
        chk_bus(1, 0, 0, RD, {4'(TB), 2'd1}, 0, 0, "R8");
        one(1, 0, mk(TB,1,1), 0, S, "R2");
        chk_bus(1, 0, 1, RD, {4'(TB), 2'd1}, 1, 0, "R7");
        one(0, 0, mk(TB,1,1), 0, S, "R7");
        chk(busq.size() == 0, "R7", "S holder hit", 64'(busq.size()), 0);
        // R6 memory captured supplied data
        one(2, 0, mk(TA,1,5), 0, E, "R6");
        chk_bus(1, 0, 2, RD, {4'(TA), 2'd1}, 0, 0, "R6");
        // R3 RFO from I invalidates a Modified remote copy
        one(2, 1, mk(TA,1,0), x3, M, "R4");
        one(0, 1, mk(TA,1,1), x4, M, "R3");
        chk_bus(1, 0, 0, RFO, {4'(TA), 2'd1}, 1, 1, "R3");
        one(2, 0, mk(TA,1,0), 0, S, "R3");
        chk_bus(1, 0, 2, RD, {4'(TA), 2'd1}, 1, 1, "R3");
        // R3 upgrade from S
        one(2, 1, mk(TA,1,3), x5, M, "R3");
        chk_bus(1, 0, 2, RFO, {4'(TA), 2'd1}, 1, 0, "R3");
        one(0, 0, mk(TA,1,1), 0, S, "R3");
        chk_bus(1, 0, 0, RD, {4'(TA), 2'd1}, 1, 1, "R3");
        one(2, 0, mk(TA,1,3), 0, S, "R6");
        // R8 dirty eviction writes back first
        one(1, 1, mk(TC,2,0), x6, M, "R3");
        chk_bus(1, 0, 1, RFO, {4'(TC), 2'd2}, 0, 0, "R3");
        one(1, 0, mk(TD,2,4), 0, E, "R8");
        chk_bus(2, 0, 1, WB, {4'(TC), 2'd2}, 0, 0, "R8");
        chk_bus(2, 1, 1, RD, {4'(TD), 2'd2}, 0, 0, "R8");
        one(2, 0, mk(TC,2,0), 0, E, "R8");
        chk_bus(1, 0, 2, RD, {4'(TC), 2'd2}, 0, 0, "R8");
        // R10 rotation: last grant core1 -> order 2,0,1
        one(1, 0, mk(5,0,0), 0, E, "R10");
        busq.delete();
        post(0, 0, mk(6,3,0), 0, E, "R10");
        post(1, 0, mk(7,3,1), 0, E, "R10");
        post(2, 0, mk(8,3,2), 0, E, "R10");
        run();
        chk_bus(3, 0, 2, RD, {4'd8, 2'd3}, 0, 0, "R10");
        chk_bus(3, 1, 0, RD, {4'd6, 2'd3}, 0, 0, "R10");
        chk_bus(3, 2, 1, RD, {4'd7, 2'd3}, 0, 0, "R10");

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule